// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits between the status outputs of an Ethernet receive frame parser and the host interrupt lines. When frames arrive close together and are all good, it takes them into one coalesced DMA burst and raises no interrupt for each frame. When the burst ends, it raises one paired interrupt. A burst ends when the inter-frame gap runs past a fixed limit, when a frame is bad, or when DMA delivery stops.

The parser gives a single-cycle `frame_done_i` strobe together with three status bits: legal length, good CRC and destination-address filter pass. A 1 MHz tick enable drives a gap timer that restarts on every completed frame. Configuration inputs select one of three delivery modes and set the interrupt enables:

- DMA for every frame.
- DMA switched in on demand.
- Programmed I/O only.

The block reports the delivery mode it has selected, whether a burst is open, and how many frames the current or last burst absorbed.

Top module: `rx_coalesce_ctrl`

## Requirements
- R1: While `rst_ni` is low, every interrupt output, `streaming_o`, `deliver_dma_o` and `absorbed_cnt_o` is 0.
- R2: A frame is good when `len_ok_i`, `crc_ok_i` and `addr_ok_i` are all 1 with `frame_done_i`. A good frame that ends while idle and with DMA delivery active opens a burst. From the next cycle `streaming_o` is 1 and `absorbed_cnt_o` is 1, and no interrupt is raised.
- R3: While streaming, a good frame that ends before the gap timer reaches GAP_US adds 1 to `absorbed_cnt_o` and raises no interrupt. A frame that follows 51 ticks after the previous one is still absorbed.
- R4: The gap timer counts `tick_us_i` pulses since the last `frame_done_i`. When it reaches GAP_US (default 52) during a burst, the burst ends on the next clock edge.
- R5: While streaming, a frame with an illegal length, a bad CRC or a failed address filter is added to `absorbed_cnt_o` and ends the burst.
- R6: At the end of a burst, `rx_ok_irq_o`, `rx_dma_irq_o` and `buf_evt_irq_o` are all high for exactly one cycle. This is the cycle after the ending condition. `absorbed_cnt_o` then holds the burst size.
- R7: Interrupt gating depends on the mode. With DMA-only set, interrupts need `cfg_dma_ie_i`. With auto-switch set and DMA-only clear, they need both `cfg_dma_ie_i` and `cfg_rxok_ie_i`. With both mode bits clear, they need `cfg_rxok_ie_i`. A gated-off burst still opens, counts and closes.
- R8: `deliver_dma_o` is `cfg_dma_only_i | (cfg_auto_sw_i & dma_need_i)`, registered with one cycle of latency.
- R9: When DMA is not active, the block never streams. A good frame then pulses `rx_ok_irq_o` alone, and `absorbed_cnt_o` is unchanged.
- R10: If DMA delivery becomes inactive during a burst, the burst ends as in R6.
- R11: Four close good frames, then a gap of more than GAP_US ticks, then five close good frames, produce exactly two `rx_dma_irq_o` pulses.
- R12: A bad frame while idle raises no interrupt, opens no burst and leaves `absorbed_cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | 1 MHz tick enable for the gap timer |
| frame_done_i | input | 1 | One-cycle strobe when a frame ends |
| len_ok_i | input | 1 | Frame length legal, valid with strobe |
| crc_ok_i | input | 1 | CRC good, valid with strobe |
| addr_ok_i | input | 1 | Destination address accepted, valid with strobe |
| cfg_dma_only_i | input | 1 | Deliver every frame by DMA |
| cfg_auto_sw_i | input | 1 | Switch to DMA on demand |
| cfg_dma_ie_i | input | 1 | DMA interrupt enable |
| cfg_rxok_ie_i | input | 1 | Receive-OK interrupt enable |
| dma_need_i | input | 1 | Demand for DMA in auto-switch mode |
| rx_ok_irq_o | output | 1 | Receive-OK interrupt pulse |
| rx_dma_irq_o | output | 1 | Receive-DMA interrupt pulse |
| buf_evt_irq_o | output | 1 | Buffer-event interrupt pulse |
| deliver_dma_o | output | 1 | 1 = DMA delivery, 0 = programmed I/O |
| streaming_o | output | 1 | Coalesced burst open |
| absorbed_cnt_o | output | ABS_W | Frames in the current or last burst |

## Verification
The checks assume the following about the inputs:

- `frame_done_i` is a one-cycle strobe and its three status bits are valid in the same cycle.
- `tick_us_i` is at most one pulse per clock.
- Mode and enable inputs change only while no burst is open. The one exception is the deliberate drop of `dma_need_i` used for R10.

The stimulus follows these rules. Frames are always at least two cycles apart, ticks are driven one per cycle, and configuration changes happen only after a burst has closed and the bench has waited several idle cycles.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_STREAM = 1'b1} rxc_state_e;
  typedef struct packed {
    logic rx_ok;
    logic rx_dma;
    logic buf_evt;
  } rxc_irq_t;
endpackage

// File: rtl/rxc_gap_timer.sv
module rxc_gap_timer #(
  parameter int unsigned GAP_US = 52
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(GAP_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_US);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so expiry stays visible until the next frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i)              cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rxc_mode_sel.sv
module rxc_mode_sel (
  input  logic dma_only_i,
  input  logic auto_sw_i,
  input  logic dma_need_i,
  input  logic dma_ie_i,
  input  logic rxok_ie_i,
  output logic dma_active_o,
  output logic pio_only_o,
  output logic irq_en_o
);
  always_comb begin
    pio_only_o   = !dma_only_i && !auto_sw_i;
    dma_active_o = dma_only_i || (auto_sw_i && dma_need_i);
    if (dma_only_i)     irq_en_o = dma_ie_i;
    else if (auto_sw_i) irq_en_o = dma_ie_i && rxok_ie_i;
    else                irq_en_o = rxok_ie_i;
  end
endmodule

// File: rtl/rxc_stream_fsm.sv
module rxc_stream_fsm
  import rxc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_done_i,
  input  logic             frame_good_i,
  input  logic             dma_active_i,
  input  logic             gap_exp_i,
  input  logic             irq_en_i,
  output logic             streaming_o,
  output logic [CNT_W-1:0] absorbed_o,
  output rxc_irq_t         irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  rxc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  rxc_irq_t         irq_q, irq_d;
  logic             end_burst;

  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign end_burst = gap_exp_i || !dma_active_i || (frame_done_i && !frame_good_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    irq_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_done_i && frame_good_i) begin
          if (dma_active_i) begin
            state_d = ST_STREAM;
            cnt_d   = CNT_W'(1);
          end else begin
            irq_d.rx_ok = irq_en_i;
          end
        end
      end
      ST_STREAM: begin
        if (frame_done_i) cnt_d = cnt_inc;
        if (end_burst) begin
          state_d = ST_IDLE;
          irq_d   = '{rx_ok: irq_en_i, rx_dma: irq_en_i, buf_evt: irq_en_i};
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      irq_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
    end
  end

  assign streaming_o = (state_q == ST_STREAM);
  assign absorbed_o  = cnt_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/rx_coalesce_ctrl.sv
module rx_coalesce_ctrl
  import rxc_pkg::*;
#(
  parameter int unsigned GAP_US = 52,
  parameter int unsigned ABS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_us_i,
  input  logic             frame_done_i,
  input  logic             len_ok_i,
  input  logic             crc_ok_i,
  input  logic             addr_ok_i,
  input  logic             cfg_dma_only_i,
  input  logic             cfg_auto_sw_i,
  input  logic             cfg_dma_ie_i,
  input  logic             cfg_rxok_ie_i,
  input  logic             dma_need_i,
  output logic             rx_ok_irq_o,
  output logic             rx_dma_irq_o,
  output logic             buf_evt_irq_o,
  output logic             deliver_dma_o,
  output logic             streaming_o,
  output logic [ABS_W-1:0] absorbed_cnt_o
);
  logic     frame_good, gap_exp, dma_active, pio_only, irq_en, deliver_q;
  rxc_irq_t irq;

  assign frame_good = len_ok_i && crc_ok_i && addr_ok_i;

  rxc_gap_timer #(.GAP_US(GAP_US)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_done_i),
    .tick_i    (tick_us_i),
    .expired_o (gap_exp)
  );

  rxc_mode_sel u_mode (
    .dma_only_i   (cfg_dma_only_i),
    .auto_sw_i    (cfg_auto_sw_i),
    .dma_need_i   (dma_need_i),
    .dma_ie_i     (cfg_dma_ie_i),
    .rxok_ie_i    (cfg_rxok_ie_i),
    .dma_active_o (dma_active),
    .pio_only_o   (pio_only),
    .irq_en_o     (irq_en)
  );

  rxc_stream_fsm #(.CNT_W(ABS_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_done_i (frame_done_i),
    .frame_good_i (frame_good),
    .dma_active_i (dma_active),
    .gap_exp_i    (gap_exp),
    .irq_en_i     (irq_en),
    .streaming_o  (streaming_o),
    .absorbed_o   (absorbed_cnt_o),
    .irq_o        (irq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) deliver_q <= 1'b0;
    else         deliver_q <= dma_active;
  end

  assign deliver_dma_o = deliver_q;
  assign rx_ok_irq_o   = irq.rx_ok;
  assign rx_dma_irq_o  = irq.rx_dma;
  assign buf_evt_irq_o = irq.buf_evt;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int unsigned ABS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_done_i,
  input logic             frame_good,
  input logic             gap_exp,
  input logic             dma_active,
  input logic             pio_only,
  input logic             irq_en,
  input logic             rx_ok_irq_o,
  input logic             rx_dma_irq_o,
  input logic             buf_evt_irq_o,
  input logic             streaming_o,
  input logic [ABS_W-1:0] absorbed_cnt_o
);
  AST_STREAM_HAS_FRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streaming_o |-> absorbed_cnt_o != '0); // R2

  AST_GAP_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streaming_o && gap_exp |=> !streaming_o); // R4

  AST_BAD_ENDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streaming_o && frame_done_i && !frame_good |=> !streaming_o); // R5

  AST_EXIT_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_irq_o |-> rx_ok_irq_o && buf_evt_irq_o); // R6

  AST_EXIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_irq_o |=> !rx_dma_irq_o); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |=> !rx_ok_irq_o && !rx_dma_irq_o && !buf_evt_irq_o); // R7

  AST_PIO_NO_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_only |=> !streaming_o); // R9

  AST_DMA_LOSS_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streaming_o && !dma_active |=> !streaming_o && (rx_dma_irq_o == $past(irq_en))); // R10
endmodule

bind rx_coalesce_ctrl rxc_checker #(.ABS_W(ABS_W)) u_rxc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_done_i   (frame_done_i),
  .frame_good     (frame_good),
  .gap_exp        (gap_exp),
  .dma_active     (dma_active),
  .pio_only       (pio_only),
  .irq_en         (irq_en),
  .rx_ok_irq_o    (rx_ok_irq_o),
  .rx_dma_irq_o   (rx_dma_irq_o),
  .buf_evt_irq_o  (buf_evt_irq_o),
  .streaming_o    (streaming_o),
  .absorbed_cnt_o (absorbed_cnt_o)
);

// File: tb/rx_coalesce_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_coalesce_ctrl_tb_top;
  localparam int ABS_W = 8;
  localparam int GAP   = 52;

  typedef struct {
    bit    ok;
    bit    dma;
    bit    bev;
    bit    use_cnt;
    int    cnt;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, fdone = 1'b0, len_ok = 1'b0, crc_ok = 1'b0, addr_ok = 1'b0;
  logic dma_only = 1'b1, auto_sw = 1'b0, dma_ie = 1'b1, rxok_ie = 1'b1, dma_need = 1'b0;
  logic rx_ok, rx_dma, bev, deliver, streaming;
  logic [ABS_W-1:0] absorbed;

  int checks = 0, fails = 0, dma_pulses = 0;
  exp_t sbq[$];
  exp_t mon_e;

  always #5 clk = ~clk;

  rx_coalesce_ctrl #(.GAP_US(GAP), .ABS_W(ABS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .frame_done_i(fdone),
    .len_ok_i(len_ok), .crc_ok_i(crc_ok), .addr_ok_i(addr_ok),
    .cfg_dma_only_i(dma_only), .cfg_auto_sw_i(auto_sw), .cfg_dma_ie_i(dma_ie),
    .cfg_rxok_ie_i(rxok_ie), .dma_need_i(dma_need),
    .rx_ok_irq_o(rx_ok), .rx_dma_irq_o(rx_dma), .buf_evt_irq_o(bev),
    .deliver_dma_o(deliver), .streaming_o(streaming), .absorbed_cnt_o(absorbed)
  );

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit ok, input bit dma, input bit b, input bit uc, input int c, input string req);
    exp_t e;
    e.ok = ok; e.dma = dma; e.bev = b; e.use_cnt = uc; e.cnt = c; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic frame(input bit l, input bit c, input bit a);
    @(negedge clk); fdone = 1'b1; len_ok = l; crc_ok = c; addr_ok = a;
    @(negedge clk); fdone = 1'b0; len_ok = 1'b0; crc_ok = 1'b0; addr_ok = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every interrupt cycle must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (rx_ok || rx_dma || bev)) begin
      if (rx_dma) dma_pulses++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R6/R7/R12", "unexpected irq {ok,dma,buf}", {rx_ok, rx_dma, bev}, 0);
      end else begin
        mon_e = sbq.pop_front();
        chk({rx_ok, rx_dma, bev} == {mon_e.ok, mon_e.dma, mon_e.bev}, mon_e.req,
            "irq {ok,dma,buf}", {rx_ok, rx_dma, bev}, {mon_e.ok, mon_e.dma, mon_e.bev});
        if (mon_e.use_cnt)
          chk(int'(absorbed) == mon_e.cnt, mon_e.req, "absorbed at irq", int'(absorbed), mon_e.cnt);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d0;
    // R1 reset state
    idle(3);
    chk({rx_ok, rx_dma, bev, deliver, streaming} == 5'b0, "R1", "flags in reset", {rx_ok, rx_dma, bev, deliver, streaming}, 0);
    chk(absorbed == 0, "R1", "absorbed in reset", absorbed, 0);
    rst_n = 1'b1;
    idle(2);
    chk(deliver == 1'b1, "R8", "deliver dma-only", deliver, 1);

    // R11 4 + gap + 5 example, also R2 R3 R4 R6
    d0 = dma_pulses;
    frame(1, 1, 1);
    chk(streaming == 1'b1, "R2", "streaming after first", streaming, 1);
    chk(absorbed == 1, "R2", "absorbed after first", absorbed, 1);
    repeat (3) begin ticks(5); frame(1, 1, 1); end
    chk(absorbed == 4, "R3", "absorbed after 4", absorbed, 4);
    push(1, 1, 1, 1, 4, "R4");
    ticks(GAP);
    idle(3);
    chk(streaming == 1'b0, "R4", "closed after gap", streaming, 0);
    frame(1, 1, 1);
    repeat (4) begin ticks(5); frame(1, 1, 1); end
    push(1, 1, 1, 1, 5, "R6");
    ticks(GAP + 8);
    idle(3);
    chk(dma_pulses - d0 == 2, "R11", "dma irq count for 9 frames", dma_pulses - d0, 2);

    // R3 boundary: 51 ticks still absorbed
    frame(1, 1, 1);
    ticks(GAP - 1);
    frame(1, 1, 1);
    chk(streaming == 1'b1, "R3", "still streaming after 51", streaming, 1);
    chk(absorbed == 2, "R3", "absorbed after 51 gap", absorbed, 2);
    push(1, 1, 1, 1, 2, "R4");
    ticks(GAP);
    idle(3);

    // R5 each kind of bad frame ends the burst
    for (int k = 0; k < 3; k++) begin
      frame(1, 1, 1);
      ticks(3);
      push(1, 1, 1, 1, 2, "R5");
      frame(k != 0, k != 1, k != 2);
      idle(2);
      chk(streaming == 1'b0, "R5", "closed by bad frame", streaming, 0);
    end

    // R12 bad frame while idle
    frame(1, 0, 1);
    idle(3);
    chk(streaming == 1'b0, "R12", "no burst on bad idle frame", streaming, 0);
    chk(absorbed == 2, "R12", "absorbed unchanged", absorbed, 2);

    // R7 dma-only without dma enable: silent burst
    dma_ie = 1'b0;
    frame(1, 1, 1);
    ticks(GAP);
    idle(3);
    chk(absorbed == 1 && streaming == 1'b0, "R7", "silent burst closed, absorbed", absorbed, 1);
    dma_ie = 1'b1;

    // R9 programmed I/O only
    dma_only = 1'b0; auto_sw = 1'b0;
    idle(2);
    chk(deliver == 1'b0, "R8", "deliver pio", deliver, 0);
    push(1, 0, 0, 1, 1, "R9");
    frame(1, 1, 1);
    idle(3);
    chk(streaming == 1'b0, "R9", "no burst in pio", streaming, 0);
    frame(0, 1, 1);
    idle(3);
    rxok_ie = 1'b0;
    frame(1, 1, 1);
    idle(3);
    chk(absorbed == 1, "R9", "absorbed unchanged in pio", absorbed, 1);
    rxok_ie = 1'b1;

    // auto-switch: no demand -> pio; demand -> dma; R10 demand loss
    auto_sw = 1'b1; dma_need = 1'b0;
    idle(2);
    chk(deliver == 1'b0, "R8", "deliver auto no need", deliver, 0);
    push(1, 0, 0, 0, 0, "R9");
    frame(1, 1, 1);
    idle(3);
    dma_need = 1'b1;
    idle(2);
    chk(deliver == 1'b1, "R8", "deliver auto need", deliver, 1);
    frame(1, 1, 1);
    ticks(3);
    frame(1, 1, 1);
    push(1, 1, 1, 1, 2, "R10");
    @(negedge clk); dma_need = 1'b0;
    idle(3);
    chk(streaming == 1'b0, "R10", "closed on dma loss", streaming, 0);

    // R7 auto mode needs both enables
    rxok_ie = 1'b0; dma_need = 1'b1;
    idle(2);
    frame(1, 1, 1);
    ticks(GAP);
    idle(3);
    chk(absorbed == 1 && streaming == 1'b0, "R7", "auto gated burst, absorbed", absorbed, 1);

    idle(4);
    chk(sbq.size() == 0, "R6", "scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule